// File: doc/BRIEF.md
# Motor Command Packet Decoder

This block sits behind a UART receiver in a motor drive. Every received byte is first written into a small ring buffer. A separate parser reads the bytes back out, one per cycle, and groups them into command packets. Each packet starts with a length byte, which counts the bytes that follow it. The next byte is a one-byte keycode, and the argument bytes come after that. Once the whole packet has been read, the block checks the keycode against its expected length and acts on it.

Four commands are recognised:

- **Network test.** The block toggles an LED and replies with a fixed four-byte pattern.
- **Software reset.** The block pulses a reset request output.
- **Speed setpoint write.** The command carries a signed 32-bit electrical-RPM target. The block stores it in a setpoint register, strobes a valid flag and replies with a one-byte acknowledge.
- **Speed readback.** The block captures the measured electrical RPM into a holding register and returns it as four bytes.

Replies are sent as raw bytes on a valid/ready byte stream toward the transmit side of the UART. While a reply is being sent, the parser waits for it to finish. During that time, incoming bytes collect in the ring buffer. Multi-byte values travel least significant byte first in both directions.

Top module: `motor_cmd_decoder`

## Requirements
- R1: After synchronous reset, all of the following are 0: `tx_valid`, `led`, `overflow`, `soft_reset`, `setpoint_valid` and `setpoint`.
- R2: A packet is a length byte N (1 to 255) followed by N bytes: the keycode, then N-1 argument bytes. A length byte of 0 is discarded on its own, and the next byte is read as a fresh length byte.
- R3: Keycode 0x7F with N=1 toggles `led` once. It replies with the bytes 0x7F, 0x0C, 0x18, 0x30, in that order.
- R4: Keycode 0x80 with N=1 raises `soft_reset` for exactly one cycle and sends no reply.
- R5: Keycode 0x8D with N=5 loads the four argument bytes, least significant first, into `setpoint`. It raises `setpoint_valid` for one cycle and replies with the single byte 0x8D. `setpoint` changes at no other time.
- R6: Keycode 0x8E with N=1 samples `meas_rpm` when the packet is decoded. It replies with the four bytes of that sample, least significant first. A later change of `meas_rpm` does not alter a reply that is already under way.
- R7: A known keycode whose length byte differs from its expected length is consumed whole and dropped. It produces no reply and no change to `led`, `setpoint` or `soft_reset`.
- R8: An unknown keycode is consumed together with its stated arguments and ignored. The following packet is decoded normally.
- R9: The ring buffer holds 64 bytes. A byte that arrives while it is full is dropped and sets `overflow`, which stays set until reset. The bytes already stored are still processed in order.
- R10: A reply byte is transferred on a cycle with `tx_valid` and `tx_ready` both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R11: Replies leave in the same order as their packets arrived. No packet is decoded while a reply is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmit side accepts the reply byte |
| tx_data | output | 8 | Reply byte |
| meas_rpm | input | 32 | Measured electrical RPM, signed |
| setpoint | output | 32 | Electrical RPM target, signed |
| setpoint_valid | output | 1 | One-cycle strobe on a new setpoint |
| soft_reset | output | 1 | One-cycle software reset request |
| led | output | 1 | LED level, toggled by the test command |
| overflow | output | 1 | Sticky flag: a byte was lost to a full buffer |

## Verification
The assertions assume that `rx_valid` and `rx_data` change only between clock edges. They also assume that `meas_rpm` is a plain level that the block may sample at any cycle. They do not assume that the transmit side ever raises `tx_ready`, so the hold property must survive arbitrary stalls.

The stimulus drives all inputs on the falling edge. It waits for each reply to drain before sending the next random packet, so the buffer overflows only in the one directed case built for it. In that case `tx_ready` is held low deliberately, which stalls the parser and lets the buffer fill.

// File: rtl/motor_cmd_pkg.sv
package motor_cmd_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);

    localparam logic [BYTE_W-1:0] KEY_PING    = 8'h7F;
    localparam logic [BYTE_W-1:0] KEY_REBOOT  = 8'h80;
    localparam logic [BYTE_W-1:0] KEY_SET_RPM = 8'h8D;
    localparam logic [BYTE_W-1:0] KEY_GET_RPM = 8'h8E;

    // fixed test reply, first byte in the low lane
    localparam logic [WORD_W-1:0] PING_WORD = {8'h30, 8'h18, 8'h0C, 8'h7F};

    typedef enum logic [2:0] {
        P_LEN,
        P_KEY,
        P_ARG,
        P_EXEC,
        P_BUSY
    } parse_state_t;

    typedef struct packed {
        logic              start;
        logic [CNT_W-1:0]  nbytes;
        logic [WORD_W-1:0] word;
    } reply_req_t;

    // frame length expected for a keycode; zero marks an unknown code
    function automatic logic [BYTE_W-1:0] expected_len(input logic [BYTE_W-1:0] key);
        case (key)
            KEY_PING, KEY_REBOOT, KEY_GET_RPM: expected_len = 8'd1;
            KEY_SET_RPM:                       expected_len = 8'd1 + 8'(WORD_BYTES);
            default:                           expected_len = 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/rx_ring.sv
module rx_ring #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop,
    output logic         overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, push_ok, pop_ok;

    assign full      = (count == FULL_CNT);
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign push_ok   = in_valid && !full;
    assign pop_ok    = pop && out_valid;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (in_valid && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
    import motor_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_pop,
    input  logic [WORD_W-1:0] meas_rpm,
    input  logic              reply_busy,
    output reply_req_t        req,
    output logic [WORD_W-1:0] setpoint,
    output logic              setpoint_valid,
    output logic              soft_reset,
    output logic              led
);
    parse_state_t      state;
    logic [BYTE_W-1:0] len_r, key_r, remain;
    logic [WORD_W-1:0] arg;

    assign byte_pop = byte_valid &&
                      (state == P_LEN || state == P_KEY || state == P_ARG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= P_LEN;
            len_r          <= '0;
            key_r          <= '0;
            remain         <= '0;
            arg            <= '0;
            req            <= '0;
            setpoint       <= '0;
            setpoint_valid <= 1'b0;
            soft_reset     <= 1'b0;
            led            <= 1'b0;
        end else begin
            setpoint_valid <= 1'b0;
            soft_reset     <= 1'b0;
            req.start      <= 1'b0;
            case (state)
                P_LEN: if (byte_pop && byte_data != '0) begin
                    len_r <= byte_data;
                    state <= P_KEY;
                end
                P_KEY: if (byte_pop) begin
                    key_r  <= byte_data;
                    remain <= len_r - 1'b1;
                    arg    <= '0;
                    state  <= (len_r == 8'd1) ? P_EXEC : P_ARG;
                end
                P_ARG: if (byte_pop) begin
                    arg    <= {byte_data, arg[WORD_W-1:BYTE_W]};
                    remain <= remain - 1'b1;
                    if (remain == 8'd1) state <= P_EXEC;
                end
                P_EXEC: begin
                    state <= P_LEN;
                    if (len_r == expected_len(key_r)) begin
                        case (key_r)
                            KEY_PING: begin
                                led   <= ~led;
                                req   <= '{start: 1'b1, nbytes: CNT_W'(WORD_BYTES), word: PING_WORD};
                                state <= P_BUSY;
                            end
                            KEY_REBOOT: soft_reset <= 1'b1;
                            KEY_SET_RPM: begin
                                setpoint       <= arg;
                                setpoint_valid <= 1'b1;
                                req   <= '{start: 1'b1, nbytes: CNT_W'(1), word: WORD_W'(KEY_SET_RPM)};
                                state <= P_BUSY;
                            end
                            KEY_GET_RPM: begin
                                req   <= '{start: 1'b1, nbytes: CNT_W'(WORD_BYTES), word: meas_rpm};
                                state <= P_BUSY;
                            end
                            default: state <= P_LEN;
                        endcase
                    end
                end
                P_BUSY: if (!reply_busy && !req.start) state <= P_LEN;
                default: state <= P_LEN;
            endcase
        end
    end
endmodule

// File: rtl/reply_tx.sv
module reply_tx
    import motor_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reply_req_t        req,
    output logic              busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data
);
    logic [WORD_W-1:0] hold;
    logic [CNT_W-1:0]  left;

    assign busy     = (left != '0);
    assign tx_valid = busy;
    assign tx_data  = hold[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            left <= '0;
        end else if (!busy && req.start) begin
            hold <= req.word;
            left <= req.nbytes;
        end else if (tx_valid && tx_ready) begin
            hold <= hold >> BYTE_W;
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/motor_cmd_decoder.sv
module motor_cmd_decoder
    import motor_cmd_pkg::*;
#(
    parameter int RING_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    input  logic [WORD_W-1:0] meas_rpm,
    output logic [WORD_W-1:0] setpoint,
    output logic              setpoint_valid,
    output logic              soft_reset,
    output logic              led,
    output logic              overflow
);
    logic              fifo_valid, fifo_pop, reply_busy;
    logic [BYTE_W-1:0] fifo_data;
    reply_req_t        req;

    rx_ring #(.DEPTH(RING_DEPTH), .W(BYTE_W)) u_ring (
        .clk(clk), .rst(rst),
        .in_valid(rx_valid), .in_data(rx_data),
        .out_valid(fifo_valid), .out_data(fifo_data),
        .pop(fifo_pop), .overflow(overflow)
    );

    cmd_parser u_parser (
        .clk(clk), .rst(rst),
        .byte_valid(fifo_valid), .byte_data(fifo_data), .byte_pop(fifo_pop),
        .meas_rpm(meas_rpm), .reply_busy(reply_busy), .req(req),
        .setpoint(setpoint), .setpoint_valid(setpoint_valid),
        .soft_reset(soft_reset), .led(led)
    );

    reply_tx u_reply (
        .clk(clk), .rst(rst), .req(req), .busy(reply_busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );
endmodule

// File: rtl/motor_cmd_checker.sv
module motor_cmd_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic [31:0] setpoint,
    input logic        setpoint_valid,
    input logic        soft_reset,
    input logic        overflow
);
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r9_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(rx_valid));

    a_r4_reset_pulse: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> !soft_reset);

    a_r5_setpoint_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(setpoint) |-> setpoint_valid);
endmodule

bind motor_cmd_decoder motor_cmd_checker u_chk (.*);

// File: tb/motor_cmd_decoder_test.sv
`timescale 1ns/1ps
module motor_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic [31:0] meas_rpm = '0;
    logic [31:0] setpoint;
    logic        setpoint_valid, soft_reset, led, overflow;

    motor_cmd_decoder uut (.*);

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;
    int ready_mode = 0;          // 0 random, 1 held low
    logic [7:0] got[$], exp[$];
    int pulses = 0, exp_pulses = 0, sp_events = 0, exp_sp_events = 0;
    logic [31:0] exp_sp = '0;
    logic exp_led = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // update ready first, then record what the next rising edge transfers
    always @(negedge clk) begin
        tx_ready = (ready_mode == 1) ? 1'b0 : 1'($urandom % 2);
        if (tx_valid && tx_ready) got.push_back(tx_data);
        if (soft_reset) pulses++;
        if (setpoint_valid) sp_events++;
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
    endtask
    task automatic idle_rx();
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pkt_ping();
        send_byte(8'h01); send_byte(8'h7F); idle_rx();
        exp.push_back(8'h7F); exp.push_back(8'h0C); exp.push_back(8'h18); exp.push_back(8'h30);
        exp_led = ~exp_led;
    endtask
    task automatic pkt_set(input logic [31:0] v);
        send_byte(8'h05); send_byte(8'h8D);
        for (int i = 0; i < 4; i++) send_byte(v[8*i +: 8]);
        idle_rx();
        exp.push_back(8'h8D); exp_sp = v; exp_sp_events++;
    endtask
    task automatic pkt_get(input logic [31:0] m);
        meas_rpm = m;
        send_byte(8'h01); send_byte(8'h8E); idle_rx();
        for (int i = 0; i < 4; i++) exp.push_back(m[8*i +: 8]);
    endtask
    task automatic pkt_reboot();
        send_byte(8'h01); send_byte(8'h80); idle_rx();
        exp_pulses++;
    endtask

    task automatic settle(input string tag);
        int g = 0;
        while (got.size() < exp.size() && g < 3000) begin @(negedge clk); g++; end
        repeat (25) @(negedge clk);
        check(got.size() == exp.size(), {tag, " reply length"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] == exp[i], {tag, " reply byte"}, got[i], exp[i]);
        got.delete(); exp.delete();
    endtask

    task automatic check_state(input string tag);
        check(led == exp_led, {tag, " R3 led"}, led, exp_led);
        check(setpoint == exp_sp, {tag, " R5 setpoint"}, setpoint, exp_sp);
        check(sp_events == exp_sp_events, {tag, " R5 strobes"}, sp_events, exp_sp_events);
        check(pulses == exp_pulses, {tag, " R4 reset pulses"}, pulses, exp_pulses);
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] m1, m2;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        check(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
        check(led == 0, "R1 led", led, 0);
        check(overflow == 0, "R1 overflow", overflow, 0);
        check(setpoint == 0, "R1 setpoint", setpoint, 0);
        check(soft_reset == 0 && setpoint_valid == 0, "R1 strobes", {soft_reset, setpoint_valid}, 0);

        // R3 test command
        pkt_ping(); settle("R3 ping"); check_state("R3");
        // R5 setpoint with sign bit set
        pkt_set(32'hFFFF_F830); settle("R5 set"); check_state("R5");
        // R4 reset request, no reply
        pkt_reboot(); settle("R4 reboot"); check_state("R4");
        // R6 readback
        pkt_get(32'h1234_5678); settle("R6 get");
        // R2 zero length byte skipped, then a normal packet
        send_byte(8'h00); idle_rx(); pkt_ping(); settle("R2 zero len"); check_state("R2");
        // R7 wrong lengths: test with an argument, setpoint short by one byte
        send_byte(8'h02); send_byte(8'h7F); send_byte(8'h00);
        send_byte(8'h04); send_byte(8'h8D); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_byte(8'h02); send_byte(8'h80); send_byte(8'h00);
        idle_rx(); settle("R7 bad length"); check_state("R7");
        // R8 unknown code with arguments, then a readback must still decode
        send_byte(8'h03); send_byte(8'h55); send_byte(8'h01); send_byte(8'h8E); idle_rx();
        pkt_get(32'hCAFE_0042); settle("R8 unknown"); check_state("R8");
        // R11 back-to-back packets come out in order
        pkt_set(32'h0000_1F40); pkt_ping(); pkt_get(32'h8000_0001);
        settle("R11 order"); check_state("R11");

        // random mix
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 6)
                0: pkt_ping();
                1: pkt_set($urandom);
                2: pkt_get($urandom);
                3: pkt_reboot();
                4: begin send_byte(8'h02); send_byte(8'h8E); send_byte(8'($urandom)); idle_rx(); end
                default: begin
                    int n = 1 + ($urandom % 4);
                    send_byte(8'(n)); send_byte(8'h20 + 8'($urandom % 64));
                    for (int k = 1; k < n; k++) send_byte(8'($urandom));
                    idle_rx();
                end
            endcase
            repeat ($urandom % 4) @(negedge clk);
            settle("R8 random");
        end
        check_state("random");

        // R6 hold and R9 overflow: stall the reply, change meas, flood buffer
        m1 = 32'hA1B2_C3D4; m2 = 32'h0BAD_F00D;
        ready_mode = 1;
        @(negedge clk);
        pkt_get(m1);
        repeat (30) @(negedge clk);
        meas_rpm = m2;
        check(tx_valid == 1, "R10 valid held", tx_valid, 1);
        check(tx_data == m1[7:0], "R10 data held", tx_data, m1[7:0]);
        check(overflow == 0, "R9 no overflow yet", overflow, 0);
        for (int p = 0; p < 35; p++) begin send_byte(8'h01); send_byte(8'h7F); end
        idle_rx();
        repeat (10) @(negedge clk);
        check(tx_data == m1[7:0], "R6 sample held", tx_data, m1[7:0]);
        check(overflow == 1, "R9 overflow set", overflow, 1);
        for (int p = 0; p < 32; p++) begin
            exp.push_back(8'h7F); exp.push_back(8'h0C); exp.push_back(8'h18); exp.push_back(8'h30);
        end
        ready_mode = 0;
        settle("R9 stored bytes");
        check(led == exp_led, "R9 led toggles", led, exp_led);
        check(overflow == 1, "R9 overflow sticky", overflow, 1);

        rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; @(negedge clk);
        check(overflow == 0, "R1 overflow cleared", overflow, 0);
        check(led == 0 && setpoint == 0, "R1 after reset", {led, setpoint}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule